// File: doc/BRIEF.md
# Predicated Vector Fold Unit

The block folds a vector of up to 64 elements into one scalar result, one element index per cycle, using an order-insensitive operation (add, multiply or bitwise OR). A per-element mask selects which elements take part; the first active element seeds the running value, and every later active element is combined with it. Each element can be a packed sub-vector of up to four lanes. When more than one lane is in use, every lane is folded separately against the same lane of the other elements.

When condition recording is enabled, every intermediate result gets a three-bit record per lane (negative, positive, zero). These records are merged into a summary. In "any" mode the summary shows which conditions at least one intermediate result met. In "all" mode it shows which conditions every intermediate result met. The result is meant for the first active destination element, and its index is reported with the result. Operations whose outcome depends on ordering are refused and raise an error flag.

Top module: `vec_fold_unit`

## Requirements
- R1: Operation codes: 0 adds, 1 multiplies and 2 ORs lane values. Each lane is EW bits wide and results wrap modulo 2^EW.
- R2: Opcodes 3 (subtract), 4 (divide) and 5 to 7 are refused. The refusal sets `err`, clears `result` and `summary`, reads no element, and pulses `done` in the cycle after the start cycle.
- R3: `start` is sampled while the block is idle, and lengths above 64 are treated as 64. `rd_idx` then walks 0, 1, ..., VL-1, one step per cycle, beginning in the cycle after the start cycle. `done` is high for the one cycle after the cycle in which `rd_idx` equals VL-1. With VL=0, `done` comes in the cycle after the start cycle.
- R4: An element whose mask bit `mask[i]` is 0 has no effect on the result, the summary or the destination index.
- R5: If exactly one element is active, that element's value is passed through unchanged. If none is active, the result is zero. In both cases the summary is zero.
- R6: Condition record per lane, as a 3-bit field: bit 2 means negative (the lane's most significant bit is set), bit 1 means positive (nonzero with the most significant bit clear), bit 0 means zero. With `all_mode`=0, the summary is the bitwise OR of the records of all intermediate results.
- R7: With `all_mode`=1, the summary is the bitwise AND of the records of all intermediate results.
- R8: With `cr_en`=0, the summary stays zero.
- R9: `dest_idx` gives the index of the first active element. It is 0 when no element is active.
- R10: `sv_lanes` selects sv_lanes+1 lanes. Lane l occupies bits [EW*l +: EW], and its summary field occupies bits [3*l +: 3]. Lanes at or above that count have a zero result and a zero summary, whatever the input data.
- R11: A `start` that arrives while the block is busy is ignored. `result`, `dest_idx`, `summary` and `err` hold their values from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fold (taken only when idle) |
| vl | input | 7 | Vector length, 0 to 64 |
| opcode | input | 3 | 0 add, 1 multiply, 2 OR, others refused |
| mask | input | 64 | Per-element predicate, bit i for element i |
| cr_en | input | 1 | Enable condition recording |
| all_mode | input | 1 | 0 any (OR of records), 1 all (AND of records) |
| sv_lanes | input | 2 | Lanes per element minus one |
| rd_idx | output | 6 | Element index being read |
| rd_data | input | 64 | Element data for rd_idx, same cycle |
| result | output | 64 | Folded value, packed lanes |
| dest_idx | output | 6 | First active element index |
| summary | output | 12 | Merged condition records, 3 bits per lane |
| busy | output | 1 | Fold in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Refused opcode |

## Verification
The hardest situation to reach from the ports is a summary that mixes the two merge modes with sparse masks. The first intermediate result must replace the summary rather than merge into it, and in "all" mode a single opposing record has to clear a bit. The stimulus fills elements with many zero lanes and values that have the sign bit set, so that the records vary. It draws masks from dense, sparse and single-bit patterns so that the first fold lands at arbitrary indices. Directed runs add a start pulse in the middle of a fold, lengths of 0 and above 64, and refused opcodes.

// File: rtl/vec_fold_unit.sv
module vec_fold_unit #(
  parameter int VLMAX = 64,
  parameter int EW    = 16,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [6:0]            vl,
  input  logic [2:0]            opcode,
  input  logic [VLMAX-1:0]      mask,
  input  logic                  cr_en,
  input  logic                  all_mode,
  input  logic [1:0]            sv_lanes,
  output logic [$clog2(VLMAX)-1:0] rd_idx,
  input  logic [LANES*EW-1:0]   rd_data,
  output logic [LANES*EW-1:0]   result,
  output logic [$clog2(VLMAX)-1:0] dest_idx,
  output logic [3*LANES-1:0]    summary,
  output logic                  busy,
  output logic                  done,
  output logic                  err
);
  localparam int IW = $clog2(VLMAX);

  logic [IW-1:0]        idx_q;
  logic [6:0]           vl_q;
  logic [2:0]           op_q;
  logic [VLMAX-1:0]     mask_q;
  logic                 cr_q, all_q;
  logic [1:0]           lanes_q;
  logic [1:0]           cnt_q;
  logic [LANES*EW-1:0]  acc_q;
  logic [3*LANES-1:0]   sum_q;
  logic [IW-1:0]        dest_q;
  logic                 busy_q, done_q, err_q;

  logic [LANES*EW-1:0]  in_val, fold_val;
  logic [3*LANES-1:0]   fold_cr;
  logic [6:0]           vl_eff;
  logic                 last, legal;

  assign vl_eff = (vl > 7'(VLMAX)) ? 7'(VLMAX) : vl;
  assign legal  = (opcode <= 3'd2);
  assign last   = ({1'b0, idx_q} == IW'(vl_q - 7'd1)) || (7'(idx_q) == vl_q - 7'd1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic          on;
    logic [EW-1:0] a, b, r;
    assign on = (l <= int'(lanes_q));
    assign a  = acc_q[EW*l +: EW];
    assign b  = on ? rd_data[EW*l +: EW] : '0;
    assign r  = (op_q == 3'd0) ? a + b :
                (op_q == 3'd1) ? a * b : a | b;
    assign in_val[EW*l +: EW]   = b;
    assign fold_val[EW*l +: EW] = on ? r : '0;
    assign fold_cr[3*l +: 3]    = !on       ? 3'b000 :
                                  (r == '0) ? 3'b001 :
                                  r[EW-1]   ? 3'b100 : 3'b010;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0; vl_q <= '0; op_q <= '0; mask_q <= '0;
      cr_q <= 1'b0; all_q <= 1'b0; lanes_q <= '0; cnt_q <= '0;
      acc_q <= '0; sum_q <= '0; dest_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        idx_q <= '0; vl_q <= vl_eff; op_q <= opcode; mask_q <= mask;
        cr_q <= cr_en; all_q <= all_mode; lanes_q <= sv_lanes;
        cnt_q <= '0; acc_q <= '0; sum_q <= '0; dest_q <= '0;
        err_q <= !legal;
        if (!legal || vl_eff == 7'd0) done_q <= 1'b1;
        else                          busy_q <= 1'b1;
      end else if (busy_q) begin
        if (mask_q[idx_q]) begin
          if (cnt_q == 2'd0) begin
            acc_q  <= in_val;
            dest_q <= idx_q;
            cnt_q  <= 2'd1;
          end else begin
            acc_q <= fold_val;
            cnt_q <= 2'd2;
            if (cr_q) begin
              if (cnt_q == 2'd1) sum_q <= fold_cr;
              else if (all_q)    sum_q <= sum_q & fold_cr;
              else               sum_q <= sum_q | fold_cr;
            end
          end
        end
        idx_q <= idx_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rd_idx   = idx_q;
  assign result   = acc_q;
  assign dest_idx = dest_q;
  assign summary  = sum_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
endmodule

module vec_fold_unit_chk #(
  parameter int VLMAX = 64,
  parameter int EW    = 16,
  parameter int LANES = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic [$clog2(VLMAX)-1:0] rd_idx,
  input logic [LANES*EW-1:0]      result,
  input logic [$clog2(VLMAX)-1:0] dest_idx,
  input logic [3*LANES-1:0]       summary,
  input logic                     busy,
  input logic                     done,
  input logic                     err
);
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_RD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rd_idx == '0); // R3
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> rd_idx == $past(rd_idx) + 1'b1); // R3
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == '0 && summary == '0)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(start)) |->
      ($stable(result) && $stable(dest_idx) && $stable(summary) && $stable(err))); // R11
endmodule

bind vec_fold_unit vec_fold_unit_chk #(.VLMAX(VLMAX), .EW(EW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_idx(rd_idx), .result(result),
  .dest_idx(dest_idx), .summary(summary), .busy(busy), .done(done), .err(err));

// File: tb/vec_fold_unit_test.sv
module vec_fold_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic [2:0]  opcode = '0;
  logic [63:0] mask = '0;
  logic        cr_en = 1'b0, all_mode = 1'b0;
  logic [1:0]  sv_lanes = '0;
  logic [5:0]  rd_idx, dest_idx;
  logic [63:0] rd_data, result;
  logic [11:0] summary;
  logic        busy, done, err;
  logic [63:0] mem [64];

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_data = mem[rd_idx];

  vec_fold_unit uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] rec(input logic [15:0] r);
    return (r == 16'd0) ? 3'b001 : r[15] ? 3'b100 : 3'b010;
  endfunction

  task automatic run(input logic [6:0] v, input logic [2:0] op, input logic [63:0] m,
                     input bit ce, input bit am, input logic [1:0] sl, input bit poke,
                     input string tag);
    int veff, cnt, cyc;
    bit idx_ok;
    logic [63:0] eres, e;
    logic [11:0] esum, cr;
    logic [5:0]  edest;
    logic [15:0] a, b, r;
    veff = (v > 7'd64) ? 64 : int'(v);
    eres = '0; esum = '0; edest = '0; cnt = 0;
    if (op <= 3'd2) begin
      for (int i = 0; i < veff; i++) begin
        if (m[i]) begin
          e = '0;
          for (int l = 0; l <= int'(sl); l++) e[16*l +: 16] = mem[i][16*l +: 16];
          if (cnt == 0) begin
            eres = e; edest = 6'(i); cnt = 1;
          end else begin
            cr = '0;
            for (int l = 0; l <= int'(sl); l++) begin
              a = eres[16*l +: 16]; b = e[16*l +: 16];
              r = (op == 3'd0) ? a + b : (op == 3'd1) ? a * b : a | b;
              eres[16*l +: 16] = r;
              cr[3*l +: 3] = rec(r);
            end
            if (ce) esum = (cnt == 1) ? cr : am ? (esum & cr) : (esum | cr);
            cnt = 2;
          end
        end
      end
    end
    @(negedge clk);
    vl = v; opcode = op; mask = m; cr_en = ce; all_mode = am; sv_lanes = sl; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1; idx_ok = 1'b1;
    while (!done && cyc < 300) begin
      if (busy && rd_idx != 6'(cyc - 1)) idx_ok = 1'b0;
      if (poke && cyc == 3) begin start = 1'b1; opcode = 3'd4; mask = ~m; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == ((op > 3'd2 || veff == 0) ? 1 : veff + 1), {tag, " R3 done timing"}, 64'(cyc),
        64'((op > 3'd2 || veff == 0) ? 1 : veff + 1));
    chk(idx_ok, {tag, " R3 rd_idx walk"}, 64'(idx_ok), 64'd1);
    chk(err == (op > 3'd2), {tag, " R2 err"}, 64'(err), 64'(op > 3'd2));
    chk(result == eres, {tag, " R1 R4 R5 R10 result"}, result, eres);
    chk(dest_idx == edest, {tag, " R9 dest_idx"}, 64'(dest_idx), 64'(edest));
    chk(summary == esum, {tag, " R6 R7 R8 summary"}, 64'(summary), 64'(esum));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    logic [63:0] hold_r;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 64; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !err && result == '0 && summary == '0, "reset state", result, 64'd0);

    // R1 each opcode, full mask
    mem[0] = 64'h0003_0002_FFFF_0005; mem[1] = 64'h0004_0003_0002_0007; mem[2] = 64'h0001_0001_0001_0001;
    run(7'd3, 3'd0, '1, 1'b1, 1'b0, 2'd3, 1'b0, "R1 add");
    run(7'd3, 3'd1, '1, 1'b1, 1'b0, 2'd3, 1'b0, "R1 mul");
    run(7'd3, 3'd2, '1, 1'b1, 1'b1, 2'd3, 1'b0, "R1 or");
    // R2 refused opcodes
    run(7'd5, 3'd3, '1, 1'b1, 1'b0, 2'd0, 1'b0, "R2 sub");
    run(7'd5, 3'd4, '1, 1'b1, 1'b0, 2'd0, 1'b0, "R2 div");
    run(7'd5, 3'd7, '1, 1'b1, 1'b0, 2'd0, 1'b0, "R2 op7");
    // R3 length edges
    run(7'd0, 3'd0, '1, 1'b1, 1'b0, 2'd0, 1'b0, "R3 vl0");
    run(7'd100, 3'd0, '1, 1'b1, 1'b0, 2'd3, 1'b0, "R3 vl clamp");
    run(7'd64, 3'd2, '1, 1'b1, 1'b1, 2'd1, 1'b0, "R3 vl64");
    // R5 one and no active elements, R9 dest
    run(7'd20, 3'd0, 64'h0000_0000_0000_0400, 1'b1, 1'b0, 2'd3, 1'b0, "R5 single");
    run(7'd20, 3'd1, 64'h0, 1'b1, 1'b0, 2'd3, 1'b0, "R5 none");
    run(7'd10, 3'd0, 64'h0000_0000_0001_0000, 1'b1, 1'b0, 2'd3, 1'b0, "R4 beyond vl");
    // R8 recording off, R7 all mode, R10 lanes
    run(7'd12, 3'd0, 64'h0F3C, 1'b0, 1'b0, 2'd3, 1'b0, "R8 cr off");
    run(7'd12, 3'd0, 64'h0F3C, 1'b1, 1'b1, 2'd3, 1'b0, "R7 all");
    run(7'd12, 3'd0, 64'h0F3C, 1'b1, 1'b0, 2'd0, 1'b0, "R10 one lane");
    run(7'd12, 3'd1, 64'h0F3C, 1'b1, 1'b1, 2'd2, 1'b0, "R10 three lanes");
    // R11 start while busy ignored, hold after done
    run(7'd10, 3'd0, 64'h3FF, 1'b1, 1'b0, 2'd3, 1'b1, "R11 poke");
    hold_r = result;
    @(negedge clk); mask = '0; opcode = 3'd1; vl = 7'd3;
    repeat (4) @(negedge clk);
    chk(result == hold_r, "R11 hold", result, hold_r);

    for (int t = 0; t < 80; t++) begin
      logic [63:0] m;
      for (int i = 0; i < 64; i++)
        for (int l = 0; l < 4; l++) begin
          case ($urandom % 4)
            0: mem[i][16*l +: 16] = 16'd0;
            1: mem[i][16*l +: 16] = 16'h8000 | 16'($urandom);
            2: mem[i][16*l +: 16] = 16'($urandom % 4);
            default: mem[i][16*l +: 16] = 16'($urandom);
          endcase
        end
      case ($urandom % 3)
        0: m = {$urandom, $urandom};
        1: m = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        default: m = 64'd1 << ($urandom % 64);
      endcase
      run(7'($urandom % 70), 3'($urandom % 4), m, 1'($urandom), 1'($urandom), 2'($urandom), 1'b0, "rand");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule